// File: doc/BRIEF.md
# Dual-Channel Serial Port Interrupt Controller

This block holds the interrupt side of a two-channel serial port, with channels A and B. A host reaches it through a single-cycle register interface. Each channel's data path is outside the block. It shows up here only as a few signals: a character-arrival strobe, a character-waiting level, the waiting character, and strobes that the block drives when the host writes or reads a holding register.

The block keeps an interrupt status register and an interrupt mask register. A status bit is latched only if its mask bit was already set before the event. Any latched event raises the single interrupt output. Only a read of channel A's status register lowers it again.

A divided-down tick input stands in for the transmitter becoming ready. On every second tick, if either transmit mask bit is set, the block latches transmit-ready on both channels at once. A command write with the transmit-disable bit set gives a flush pulse to that channel's data path.

Top module: `duart_irq_ctrl`

## Requirements
- R1: After reset the interrupt status register reads 0x00, the mask register is 0x00, the tick counter is at zero and `irq` is low.
- R2: The status/mask address is 6. A write there loads the mask register with `wdata & 0x33`. A read there returns the status register with this layout: bit 0 = TX ready A, bit 1 = RX ready A, bit 4 = TX ready B, bit 5 = RX ready B, all other bits 0.
- R3: An arrival strobe on a channel sets that channel's RX status bit on the next edge only if the matching mask bit was set before that cycle. A mask write in the same cycle does not qualify the event.
- R4: A read of a channel status register (A at address 0, B at address 3) returns bit 0 = that channel's character-waiting level, bit 2 = 1, and all other bits 0.
- R5: A read of channel A's status register drops `irq` on the next edge unless a qualifying event lands in the same cycle. A read of channel B's status register leaves `irq` unchanged. Neither read changes the status register.
- R6: A write to a holding register (A at address 2, B at address 5) gives a one-cycle `tx_push` strobe carrying `wdata[7:0]` and clears that channel's TX status bit. A read of a holding register returns that channel's character, gives a one-cycle `rx_pop` strobe and clears that channel's RX status bit.
- R7: Tick pulses are counted modulo `TICK_DIV` (default 2). On the pulse that wraps the counter to zero, if mask bit 0 or mask bit 4 is set, both TX status bits (0 and 4) are set. If neither is set, nothing is latched.
- R8: A write to a command register (A at address 1, B at address 4) with `wdata` bit 3 set drives that channel's `flush` high during the write cycle. The same write with bit 3 clear does not.
- R9: `irq` rises on the edge after any latched status event. It then stays high until a channel A status read clears it.
- R10: When a set and a clear of the same status bit, or of `irq`, fall in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while `bus_rd` is high, zero otherwise |
| rx_arrive_a | input | 1 | Channel A character arrived (pulse) |
| rx_arrive_b | input | 1 | Channel B character arrived (pulse) |
| rx_avail_a | input | 1 | Channel A character waiting (level) |
| rx_avail_b | input | 1 | Channel B character waiting (level) |
| rx_char_a | input | 8 | Channel A received character |
| rx_char_b | input | 8 | Channel B received character |
| tick | input | 1 | Periodic tick pulse |
| tx_char | output | 8 | Character handed to the transmit data path |
| tx_push_a | output | 1 | Channel A holding-register write strobe |
| tx_push_b | output | 1 | Channel B holding-register write strobe |
| rx_pop_a | output | 1 | Channel A holding-register read strobe |
| rx_pop_b | output | 1 | Channel B holding-register read strobe |
| flush_a | output | 1 | Channel A transmit flush pulse |
| flush_b | output | 1 | Channel B transmit flush pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle:
- `irq` only rises after a latched event, and it only falls after a channel A status read.
- A qualified arrival or a tick injection shows up in the status register on the next edge.
- No two data-path strobes are ever active together.
- A flush only comes from a command write with bit 3 set.

Some behaviours only the bench scenarios can show:
- An event is refused when its mask is written in the same cycle.
- The tick counter really starts at zero and wraps every second pulse.
- Channel B status reads leave `irq` alone.
- The set-over-clear priority holds when an arrival and a holding read hit the same bit.

// File: rtl/duart_irq_pkg.sv
package duart_irq_pkg;

  localparam int ADDR_W = 3;
  localparam int NUM_CH = 2;
  localparam int REG_W  = 8;
  localparam int CH_STRIDE = 3;   // registers per channel block
  localparam int CLR_CH = 0;      // channel whose status read clears irq

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT_A = 3'd0,
    REG_CMD_A  = 3'd1,
    REG_HOLD_A = 3'd2,
    REG_STAT_B = 3'd3,
    REG_CMD_B  = 3'd4,
    REG_HOLD_B = 3'd5,
    REG_INTR   = 3'd6,
    REG_NONE   = 3'd7
  } reg_sel_e;

  localparam logic [REG_W-1:0] IRQ_FIELD_MASK = 8'h33;
  localparam int STAT_RX_BIT   = 0;
  localparam int STAT_TX_BIT   = 2;
  localparam int CMD_TXOFF_BIT = 3;

  typedef struct packed {
    logic tx_push;
    logic rx_pop;
    logic flush;
    logic stat_rd;
  } chan_req_t;

  // status/mask field positions per channel
  function automatic int tx_bit(input int ch);
    return 4 * ch;
  endfunction

  function automatic int rx_bit(input int ch);
    return 4 * ch + 1;
  endfunction

  // first register of a channel block
  function automatic logic [ADDR_W-1:0] ch_base(input int ch);
    return ADDR_W'(ch * CH_STRIDE);
  endfunction

  // channel status register contents
  function automatic logic [REG_W-1:0] chan_status(input logic avail);
    logic [REG_W-1:0] v;
    v = '0;
    v[STAT_RX_BIT] = avail;
    v[STAT_TX_BIT] = 1'b1;
    return v;
  endfunction

  // status update: set has priority over clear
  function automatic logic [REG_W-1:0] isr_next(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] set,
                                                input logic [REG_W-1:0] clr);
    return ((cur & ~clr) | set) & IRQ_FIELD_MASK;
  endfunction

endpackage

// File: rtl/duart_irq_decode.sv
module duart_irq_decode
  import duart_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [DATA_W-1:0]            bus_wdata,
  output chan_req_t [NUM_CH-1:0]       req,
  output logic                         mask_wr
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_STAT = ch_base(c);
    localparam logic [ADDR_W-1:0] A_CMD  = ch_base(c) + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_HOLD = ch_base(c) + ADDR_W'(2);

    assign req[c].stat_rd = bus_rd && (bus_addr == A_STAT);
    assign req[c].flush   = bus_wr && (bus_addr == A_CMD) && bus_wdata[CMD_TXOFF_BIT];
    assign req[c].tx_push = bus_wr && (bus_addr == A_HOLD);
    assign req[c].rx_pop  = bus_rd && (bus_addr == A_HOLD);
  end

  assign mask_wr = bus_wr && (bus_addr == REG_INTR);

endmodule

// File: rtl/duart_irq_tick.sv
module duart_irq_tick #(
  parameter int TICK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic wrap
);

  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap = tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/duart_irq_state.sv
module duart_irq_state
  import duart_irq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  chan_req_t [NUM_CH-1:0]   req,
  input  logic [NUM_CH-1:0]        rx_arrive,
  input  logic                     mask_wr,
  input  logic [REG_W-1:0]         mask_data,
  input  logic                     tick_wrap,
  output logic [REG_W-1:0]         isr_q,
  output logic [REG_W-1:0]         imr_q,
  output logic                     irq,
  output logic [REG_W-1:0]         ev_set,
  output logic                     tx_inject
);

  logic [REG_W-1:0] ev_clr;
  logic             tx_masked;
  logic             irq_clr;

  always_comb begin
    tx_masked = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      tx_masked = tx_masked | imr_q[tx_bit(c)];
    end
  end

  assign tx_inject = tick_wrap && tx_masked;
  assign irq_clr   = req[CLR_CH].stat_rd;

  always_comb begin
    ev_set = '0;
    ev_clr = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      ev_set[rx_bit(c)] = rx_arrive[c] & imr_q[rx_bit(c)];
      ev_set[tx_bit(c)] = tx_inject;
      ev_clr[rx_bit(c)] = req[c].rx_pop;
      ev_clr[tx_bit(c)] = req[c].tx_push;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      imr_q <= '0;
      irq   <= 1'b0;
    end else begin
      isr_q <= isr_next(isr_q, ev_set, ev_clr);
      if (mask_wr) begin
        imr_q <= mask_data & IRQ_FIELD_MASK;
      end
      if (|ev_set) begin
        irq <= 1'b1;
      end else if (irq_clr) begin
        irq <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/duart_irq_ctrl.sv
module duart_irq_ctrl
  import duart_irq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_arrive_a,
  input  logic              rx_arrive_b,
  input  logic              rx_avail_a,
  input  logic              rx_avail_b,
  input  logic [7:0]        rx_char_a,
  input  logic [7:0]        rx_char_b,
  input  logic              tick,
  output logic [7:0]        tx_char,
  output logic              tx_push_a,
  output logic              tx_push_b,
  output logic              rx_pop_a,
  output logic              rx_pop_b,
  output logic              flush_a,
  output logic              flush_b,
  output logic              irq
);

  chan_req_t [NUM_CH-1:0] req;
  logic                   mask_wr;
  logic                   tick_wrap;
  logic [REG_W-1:0]       isr_q;
  logic [REG_W-1:0]       imr_q;
  logic [REG_W-1:0]       ev_set;
  logic                   tx_inject;
  logic [REG_W-1:0]       rd_byte;

  duart_irq_decode #(.DATA_W(DATA_W)) i_decode (
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .req       (req),
    .mask_wr   (mask_wr)
  );

  duart_irq_tick #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .wrap  (tick_wrap)
  );

  duart_irq_state i_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .rx_arrive ({rx_arrive_b, rx_arrive_a}),
    .mask_wr   (mask_wr),
    .mask_data (bus_wdata[REG_W-1:0]),
    .tick_wrap (tick_wrap),
    .isr_q     (isr_q),
    .imr_q     (imr_q),
    .irq       (irq),
    .ev_set    (ev_set),
    .tx_inject (tx_inject)
  );

  // read mux
  always_comb begin
    rd_byte = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        REG_STAT_A: rd_byte = chan_status(rx_avail_a);
        REG_STAT_B: rd_byte = chan_status(rx_avail_b);
        REG_HOLD_A: rd_byte = rx_char_a;
        REG_HOLD_B: rd_byte = rx_char_b;
        REG_INTR:   rd_byte = isr_q;
        default:    rd_byte = '0;
      endcase
    end
  end

  assign bus_rdata = DATA_W'(rd_byte);
  assign tx_char   = bus_wdata[7:0];
  assign tx_push_a = req[0].tx_push;
  assign tx_push_b = req[1].tx_push;
  assign rx_pop_a  = req[0].rx_pop;
  assign rx_pop_b  = req[1].rx_pop;
  assign flush_a   = req[0].flush;
  assign flush_b   = req[1].flush;

endmodule

// File: rtl/duart_irq_ctrl_chk.sv
module duart_irq_ctrl_chk
  import duart_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rx_arrive_a,
  input logic              rx_arrive_b,
  input logic              tx_push_a,
  input logic              tx_push_b,
  input logic              rx_pop_a,
  input logic              rx_pop_b,
  input logic              flush_a,
  input logic              flush_b,
  input logic              irq,
  input logic [7:0]        isr_q,
  input logic [7:0]        imr_q,
  input logic [7:0]        ev_set,
  input logic              tx_inject
);

  logic stat_a_rd;
  assign stat_a_rd = bus_rd && (bus_addr == REG_STAT_A);

  // R5: channel A status read with no concurrent event drops irq
  a_r5_stat_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_a_rd && (ev_set == 8'h00)) |=> !irq);

  // R5: a status read without holding access or events leaves the status register alone
  a_r5_stat_read_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_a_rd && !bus_wr && (ev_set == 8'h00)) |=> (isr_q == $past(isr_q)));

  // R9: irq holds until a channel A status read
  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_a_rd) |=> irq);

  // R9: irq only rises after a latched event
  a_r9_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (ev_set == 8'h00)) |=> !irq);

  // R3: qualified arrivals latch and raise irq
  a_r3_rx_latch_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_arrive_a && imr_q[1]) |=> (isr_q[1] && irq));
  a_r3_rx_latch_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_arrive_b && imr_q[5]) |=> (isr_q[5] && irq));

  // R7: tick injection sets both TX bits
  a_r7_tick_both_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inject |=> (isr_q[0] && isr_q[4] && irq));

  // R6: at most one data-path strobe at a time
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_push_a, tx_push_b, rx_pop_a, rx_pop_b}));

  // R8: flush only from a command write with bit 3 set
  a_r8_flush_a_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_a |-> (bus_wr && (bus_addr == REG_CMD_A) && bus_wdata[CMD_TXOFF_BIT]));
  a_r8_flush_b_cause: assert property (@(posedge clk) disable iff (!rst_n)
    flush_b |-> (bus_wr && (bus_addr == REG_CMD_B) && bus_wdata[CMD_TXOFF_BIT]));

endmodule

bind duart_irq_ctrl duart_irq_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .rx_arrive_a (rx_arrive_a),
  .rx_arrive_b (rx_arrive_b),
  .tx_push_a   (tx_push_a),
  .tx_push_b   (tx_push_b),
  .rx_pop_a    (rx_pop_a),
  .rx_pop_b    (rx_pop_b),
  .flush_a     (flush_a),
  .flush_b     (flush_b),
  .irq         (irq),
  .isr_q       (isr_q),
  .imr_q       (imr_q),
  .ev_set      (ev_set),
  .tx_inject   (tx_inject)
);

// File: tb/test_duart_irq_ctrl.sv
`timescale 1ns/1ps
module test_duart_irq_ctrl;

  localparam int DIV = 2;
  localparam logic [2:0] SA = 3'd0, CA = 3'd1, HA = 3'd2,
                         SB = 3'd3, CB = 3'd4, HB = 3'd5, IR = 3'd6, NO = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = NO;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_arrive_a = 1'b0, rx_arrive_b = 1'b0;
  logic       rx_avail_a = 1'b0, rx_avail_b = 1'b0;
  logic [7:0] rx_char_a = '0, rx_char_b = '0;
  logic       tick = 1'b0;
  logic [7:0] tx_char;
  logic       tx_push_a, tx_push_b, rx_pop_a, rx_pop_b, flush_a, flush_b, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  duart_irq_ctrl i_duart_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_arrive_a(rx_arrive_a), .rx_arrive_b(rx_arrive_b),
    .rx_avail_a(rx_avail_a), .rx_avail_b(rx_avail_b),
    .rx_char_a(rx_char_a), .rx_char_b(rx_char_b), .tick(tick),
    .tx_char(tx_char), .tx_push_a(tx_push_a), .tx_push_b(tx_push_b),
    .rx_pop_a(rx_pop_a), .rx_pop_b(rx_pop_b),
    .flush_a(flush_a), .flush_b(flush_b), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_isr, m_imr, m_irq, m_cnt;

  always @(posedge clk) begin
    int set, clr;
    if (!rst_n) begin
      m_isr = 0; m_imr = 0; m_irq = 0; m_cnt = 0;
    end else begin
      set = 0; clr = 0;
      if (rx_arrive_a && (m_imr & 'h02) != 0) set = set | 'h02;
      if (rx_arrive_b && (m_imr & 'h20) != 0) set = set | 'h20;
      if (tick) begin
        m_cnt = m_cnt + 1;
        if (m_cnt == DIV) begin
          m_cnt = 0;
          if ((m_imr & 'h11) != 0) set = set | 'h11;
        end
      end
      if (bus_wr && bus_addr == HA) clr = clr | 'h01;
      if (bus_wr && bus_addr == HB) clr = clr | 'h10;
      if (bus_rd && bus_addr == HA) clr = clr | 'h02;
      if (bus_rd && bus_addr == HB) clr = clr | 'h20;
      m_isr = (m_isr & ~clr) | set;
      if (bus_wr && bus_addr == IR) m_imr = bus_wdata & 'h33;
      if (set != 0) m_irq = 1;
      else if (bus_rd && bus_addr == SA) m_irq = 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    int exp_rd;
    if (rst_n && !done) begin
      exp_rd = 0;
      if (bus_rd) begin
        case (bus_addr)
          SA: exp_rd = 'h04 | int'(rx_avail_a);
          SB: exp_rd = 'h04 | int'(rx_avail_b);
          HA: exp_rd = rx_char_a;
          HB: exp_rd = rx_char_b;
          IR: exp_rd = m_isr;
          default: exp_rd = 0;
        endcase
      end
      chk("R9 irq vs model", 32'(irq), 32'(m_irq));
      chk("R2/R4 read data vs model", 32'(bus_rdata), 32'(exp_rd));
      chk("R6 push/pop strobes", {28'd0, tx_push_a, tx_push_b, rx_pop_a, rx_pop_b},
          {28'd0, bus_wr && bus_addr == HA, bus_wr && bus_addr == HB,
                  bus_rd && bus_addr == HA, bus_rd && bus_addr == HB});
      chk("R8 flush strobes", {30'd0, flush_a, flush_b},
          {30'd0, bus_wr && bus_addr == CA && bus_wdata[3],
                  bus_wr && bus_addr == CB && bus_wdata[3]});
      if (tx_push_a || tx_push_b) chk("R6 tx_char", 32'(tx_char), 32'(bus_wdata));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(input logic [2:0] a, input logic w, input logic r, input logic [7:0] d,
                       input logic arr_a, input logic arr_b, input logic tk);
    @(posedge clk);
    #2;
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    rx_arrive_a = arr_a; rx_arrive_b = arr_b; tick = tk;
  endtask

  task automatic idle();
    drive(NO, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    drive(a, 1'b1, 1'b0, d, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    drive(a, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    #1;
    chk(tag, 32'(bus_rdata), 32'(exp));
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    idle();
    #1;
    chk(tag, 32'(irq), 32'(exp));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    irq_chk(1'b0, "R1 irq after reset");
    rd_chk(IR, 8'h00, "R1 status after reset");

    // R3: masked arrival is ignored
    drive(NO, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0);
    irq_chk(1'b0, "R3 masked arrival irq");
    rd_chk(IR, 8'h00, "R3 masked arrival status");

    // R3: mask written in the same cycle does not qualify
    drive(IR, 1'b1, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0);
    irq_chk(1'b0, "R3 same-cycle mask irq");
    rd_chk(IR, 8'h00, "R3 same-cycle mask status");

    // R3/R9: qualified arrival on A
    drive(NO, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    irq_chk(1'b1, "R9 irq after arrival");
    rd_chk(IR, 8'h02, "R2 status RX A");

    // R5: channel B status read keeps irq, A drops it, status unchanged
    rd_chk(SB, 8'h04, "R4 status B idle");
    irq_chk(1'b1, "R5 B read keeps irq");
    rd_chk(SA, 8'h04, "R4 status A idle");
    irq_chk(1'b0, "R5 A read drops irq");
    rd_chk(IR, 8'h02, "R5 status kept after A read");
    repeat (3) idle();
    irq_chk(1'b0, "R9 irq stays low");

    // R6: holding read returns char, clears RX A
    rx_char_a = 8'h5A;
    rd_chk(HA, 8'h5A, "R6 holding read A");
    idle();
    rd_chk(IR, 8'h00, "R6 RX A cleared");

    // R4: character-waiting level
    rx_avail_a = 1'b1;
    rd_chk(SA, 8'h05, "R4 status A waiting");
    rx_avail_b = 1'b1;
    rd_chk(SB, 8'h05, "R4 status B waiting");
    rx_avail_a = 1'b0; rx_avail_b = 1'b0;

    // R7 and R1: counter starts at zero, second tick injects
    wr(IR, 8'h01);
    drive(NO, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    irq_chk(1'b0, "R7 first tick no event");
    rd_chk(IR, 8'h00, "R1 tick counter starts at zero");
    drive(NO, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    irq_chk(1'b1, "R7 second tick irq");
    rd_chk(IR, 8'h11, "R7 both TX bits");

    // R6: holding write on B clears only TX B
    wr(HB, 8'h41);
    #1;
    chk("R6 push B", 32'(tx_push_b), 32'd1);
    chk("R6 tx_char", 32'(tx_char), 32'h41);
    idle();
    rd_chk(IR, 8'h01, "R6 TX B cleared");

    // R8: flush pulses
    wr(CA, 8'h08);
    #1;
    chk("R8 flush A", {30'd0, flush_a, flush_b}, 32'h2);
    wr(CB, 8'h07);
    #1;
    chk("R8 no flush without bit3", 32'(flush_b), 32'd0);
    wr(CB, 8'h0F);
    #1;
    chk("R8 flush B", {30'd0, flush_a, flush_b}, 32'h1);
    idle();
    #1;
    chk("R8 flush ends", {30'd0, flush_a, flush_b}, 32'h0);

    // R7: wrap with no TX mask latches nothing
    wr(IR, 8'h00);
    rd_chk(SA, 8'h04, "R4 status A");
    drive(NO, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    drive(NO, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    irq_chk(1'b0, "R7 unmasked wrap no irq");
    rd_chk(IR, 8'h01, "R7 unmasked wrap status");

    // R10: set beats clear for a status bit and for irq
    wr(IR, 8'h20);
    drive(HB, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0);
    idle();
    rd_chk(IR, 8'h21, "R10 set beats holding clear");
    drive(SA, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0);
    irq_chk(1'b1, "R10 set beats irq clear");
    rd_chk(SA, 8'h04, "R4 status A again");
    irq_chk(1'b0, "R5 irq cleared");

    // R6: holding write A clears TX A
    wr(HA, 8'h33);
    idle();
    rd_chk(IR, 8'h20, "R6 TX A cleared");

    // mixed traffic, compared cycle by cycle against the model
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      logic       w;
      a = 3'($urandom_range(0, 7));
      w = 1'($urandom_range(0, 1));
      rx_avail_a = 1'($urandom_range(0, 1));
      rx_avail_b = 1'($urandom_range(0, 1));
      rx_char_a  = 8'($urandom);
      rx_char_b  = 8'($urandom);
      drive(a, w, !w, 8'($urandom),
            1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
            1'($urandom_range(0, 2) == 0));
    end
    idle();
    @(posedge clk);
    #4;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule